// File: doc/BRIEF.md
# 8-to-16-Bit Bus Width Bridge

This block lets a processor with an 8-bit data bus reach peripherals that have a 16-bit data port, such as a disk interface or a network controller. Each 16-bit transfer is split into two consecutive byte cycles. Address bit 0 tells the two halves apart, and the processor always issues the half with A0=0 first.

The two directions touch the device in different halves. A read reaches the device in the first cycle: one byte goes straight to the processor and the other is kept for the second cycle, which only returns that kept byte. A write reaches the device in the second cycle: the first cycle only keeps the byte, and the second cycle issues one 16-bit device write that combines the kept byte with the current one. A cycle that does not touch the device is acknowledged by the bridge itself one clock later. Each device has a swap-enable input that exchanges the two byte lanes, for devices that store the low-order byte in bits 15:8.

Top module: `byte_pair_bridge`

## Requirements
- R1: After reset `cpu_ack`, `dev_rd` and `dev_wr` are low, `cpu_rdata` is 0x00, and both held bytes are 0x00. An A0=1 read issued before any first half returns 0x00, and an A0=1 write issued before any first half sends 0x00 in the held-byte lane.
- R2: A read with A0=0 raises the `dev_rd` bit of the selected device from the clock after the request until the clock after `dev_done`. `cpu_ack` rises one clock later, and with swap off `cpu_rdata` then equals device bits 7:0.
- R3: A read with A0=1 raises no device strobe. `cpu_ack` is high one clock after the request, with `cpu_rdata` equal to the byte held from the last A0=0 read (device bits 15:8 with swap off), even if the device data has changed since.
- R4: A write with A0=0 raises no device strobe and is acknowledged one clock after the request. It holds `cpu_wdata` for the next A0=1 write.
- R5: A write with A0=1 raises the `dev_wr` bit of the selected device in the same way as R2. With swap off, `dev_wdata` stays stable at {current `cpu_wdata`, held byte} while the strobe is high.
- R6: When the selected device's `dev_swap` bit is 1, the lanes are exchanged. The A0=0 read returns bits 15:8 and the A0=1 read returns bits 7:0, and the write sends {held byte, current byte}.
- R7: `cpu_ack` stays high while `cpu_req` stays high, and it drops one clock after `cpu_req` drops. A new request is only taken after that.
- R8: At most one strobe bit is high at any time. When several `dev_sel` bits are set, the lowest-numbered device is used.
- R9: A request with no `dev_sel` bit set is ignored. It gives no strobe and no acknowledge, and it leaves the held bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Byte cycle request, held until `cpu_ack` |
| cpu_a0 | input | 1 | Address bit 0: 0 = first half, 1 = second half |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Processor write byte |
| dev_sel | input | N_DEV | Device select, one bit per device |
| dev_swap | input | N_DEV | Per-device byte-lane exchange enable |
| dev_rdata | input | 16*N_DEV | Device read words, device i at bits 16i+15:16i |
| dev_done | input | 1 | Device has finished the strobed access |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Byte cycle complete |
| dev_wdata | output | 16 | Device write word |
| dev_rd | output | N_DEV | Per-device read strobe |
| dev_wr | output | N_DEV | Per-device write strobe |

## Verification
Write pairs and read pairs are swept over eight computed byte pairs, on both devices, with lane exchange both off and on. Distinct high and low bytes show whether the lanes are swapped, and changing the device word between the two read halves shows whether the second half really comes from the held byte rather than a new device access. Strobe counts and acknowledge latency show which half touched the device. Extra cases cover A0=1 accesses straight after reset, a select with both bits set, a request with no select, and a request held long after its acknowledge.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEV  = 2'd1,
    ST_ACK  = 2'd2
  } bwb_state_e;
endpackage

// File: rtl/bwb_pick.sv
// Lowest-numbered asserted select wins.
module bwb_pick #(
  parameter int unsigned N_DEV = 2,
  localparam int unsigned IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0] sel,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (sel[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bwb_lanes.sv
// Optional exchange of the two byte lanes of a word.
module bwb_lanes #(
  parameter int unsigned BW = 8
) (
  input  logic            swap,
  input  logic [2*BW-1:0] din,
  output logic [2*BW-1:0] dout
);
  assign dout = swap ? {din[BW-1:0], din[2*BW-1:BW]} : din;
endmodule

// File: rtl/bwb_fsm.sv
module bwb_fsm
  import bwb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       any_sel,
  input  logic       needs_dev,
  input  logic       dev_done,
  output bwb_state_e state,
  output logic       start,
  output logic       finish
);
  bwb_state_e state_nxt;

  assign start  = (state == ST_IDLE) && req && any_sel;
  assign finish = (state == ST_DEV) && dev_done;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: if (start) state_nxt = needs_dev ? ST_DEV : ST_ACK;
      ST_DEV:  if (dev_done) state_nxt = ST_ACK;
      ST_ACK:  if (!req) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/byte_pair_bridge.sv
module byte_pair_bridge
  import bwb_pkg::*;
#(
  parameter int unsigned N_DEV = 2,
  localparam int unsigned IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_a0,
  input  logic                    cpu_we,
  input  logic [BYTE_W-1:0]       cpu_wdata,
  input  logic [N_DEV-1:0]        dev_sel,
  input  logic [N_DEV-1:0]        dev_swap,
  input  logic [N_DEV*WORD_W-1:0] dev_rdata,
  input  logic                    dev_done,
  output logic [BYTE_W-1:0]       cpu_rdata,
  output logic                    cpu_ack,
  output logic [WORD_W-1:0]       dev_wdata,
  output logic [N_DEV-1:0]        dev_rd,
  output logic [N_DEV-1:0]        dev_wr
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic          any_sel, needs_dev, start, finish;
  logic [IW-1:0] pick_idx;
  bwb_state_e    state;

  bwb_pick #(.N_DEV(N_DEV)) i_pick (
    .sel(dev_sel), .any(any_sel), .idx(pick_idx)
  );

  // Reads touch the device on A0=0, writes on A0=1.
  assign needs_dev = (cpu_we == cpu_a0);

  bwb_fsm i_fsm (
    .clk(clk), .rst_n(rst_int_n), .req(cpu_req), .any_sel(any_sel),
    .needs_dev(needs_dev), .dev_done(dev_done),
    .state(state), .start(start), .finish(finish)
  );

  // Held-cycle registers.
  logic [IW-1:0]     idx_q;
  logic              we_q, swap_q;
  logic [BYTE_W-1:0] wlatch_q, rlatch_q, rdata_q;
  logic [WORD_W-1:0] wdata_q;

  // Clock enables.
  logic en_cap, en_wlatch, en_rlocal, en_wword, en_rword;
  assign en_cap    = start && needs_dev;
  assign en_wlatch = start && !needs_dev && cpu_we;
  assign en_rlocal = start && !needs_dev && !cpu_we;
  assign en_wword  = en_cap && cpu_we;
  assign en_rword  = finish && !we_q;

  // Write word: current byte high, held byte low, then optional exchange.
  logic [WORD_W-1:0] wword;
  bwb_lanes #(.BW(BYTE_W)) i_wlanes (
    .swap(dev_swap[pick_idx]), .din({cpu_wdata, wlatch_q}), .dout(wword)
  );

  // Read word of the device under access, optionally exchanged.
  logic [WORD_W-1:0] rword_raw, rword;
  assign rword_raw = dev_rdata[int'(idx_q)*WORD_W +: WORD_W];
  bwb_lanes #(.BW(BYTE_W)) i_rlanes (
    .swap(swap_q), .din(rword_raw), .dout(rword)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      idx_q    <= '0;
      we_q     <= 1'b0;
      swap_q   <= 1'b0;
      wlatch_q <= '0;
      rlatch_q <= '0;
      rdata_q  <= '0;
      wdata_q  <= '0;
    end else begin
      if (en_cap) begin
        idx_q  <= pick_idx;
        we_q   <= cpu_we;
        swap_q <= dev_swap[pick_idx];
      end
      if (en_wlatch) wlatch_q <= cpu_wdata;
      if (en_wword)  wdata_q  <= wword;
      if (en_rlocal) rdata_q  <= rlatch_q;
      if (en_rword) begin
        rdata_q  <= rword[BYTE_W-1:0];
        rlatch_q <= rword[WORD_W-1:BYTE_W];
      end
    end
  end

  for (genvar g = 0; g < N_DEV; g++) begin : g_stb
    assign dev_rd[g] = (state == ST_DEV) && !we_q && (idx_q == IW'(g));
    assign dev_wr[g] = (state == ST_DEV) &&  we_q && (idx_q == IW'(g));
  end

  assign cpu_ack   = (state == ST_ACK);
  assign cpu_rdata = rdata_q;
  assign dev_wdata = wdata_q;
endmodule

// File: rtl/bwb_chk.sv
module bwb_chk #(
  parameter int unsigned N_DEV = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_a0,
  input logic               cpu_we,
  input logic [N_DEV-1:0]   dev_sel,
  input logic               cpu_ack,
  input logic [15:0]        dev_wdata,
  input logic [N_DEV-1:0]   dev_rd,
  input logic [N_DEV-1:0]   dev_wr
);
  // R2
  rd_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_rd) |-> (!cpu_a0 && !cpu_we));

  // R5
  wr_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_wr) |-> (cpu_a0 && cpu_we));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_rd, dev_wr}));

  // R3
  local_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_req) && (|dev_sel) && (cpu_a0 != cpu_we)) |=> cpu_ack);

  // R7
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_req) |=> cpu_ack);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_req) |=> !cpu_ack);

  // R5
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_wr) && $past(|dev_wr)) |-> $stable(dev_wdata));

  // R9
  no_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !(|dev_sel) && !cpu_ack) |=> !cpu_ack);
endmodule

bind byte_pair_bridge bwb_chk #(.N_DEV(N_DEV)) i_bwb_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_a0(cpu_a0),
  .cpu_we(cpu_we), .dev_sel(dev_sel), .cpu_ack(cpu_ack),
  .dev_wdata(dev_wdata), .dev_rd(dev_rd), .dev_wr(dev_wr)
);

// File: tb/test_byte_pair_bridge.sv
`timescale 1ns/1ps
module test_byte_pair_bridge;
  localparam int N = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_a0 = 1'b0, cpu_we = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [N-1:0]  dev_sel = '0, dev_swap = '0;
  logic [N*16-1:0] dev_rdata = '0;
  logic          dev_done;
  logic [7:0]    cpu_rdata;
  logic          cpu_ack;
  logic [15:0]   dev_wdata;
  logic [N-1:0]  dev_rd, dev_wr;

  always #2.5 clk = ~clk;

  byte_pair_bridge #(.N_DEV(N)) i_byte_pair_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_a0(cpu_a0),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .dev_sel(dev_sel),
    .dev_swap(dev_swap), .dev_rdata(dev_rdata), .dev_done(dev_done),
    .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .dev_wdata(dev_wdata),
    .dev_rd(dev_rd), .dev_wr(dev_wr)
  );

  // Device model: finishes on the third cycle of a strobe.
  logic [1:0] dly = 2'b00;
  wire  stb_any = (|dev_rd) || (|dev_wr);
  always @(posedge clk) dly <= stb_any ? {dly[0], 1'b1} : 2'b00;
  assign dev_done = dly[1] && stb_any;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Results of the last bus cycle.
  logic [7:0]   r_data;
  int           r_lat, r_stb;
  logic [15:0]  r_word;
  logic [N-1:0] r_rdmask, r_wrmask;

  task automatic cyc(input logic a0, input logic we, input logic [7:0] wd,
                     input logic [N-1:0] sel, input int hold);
    @(negedge clk);
    cpu_a0 = a0; cpu_we = we; cpu_wdata = wd; dev_sel = sel; cpu_req = 1'b1;
    r_lat = 0; r_stb = 0; r_word = 'x; r_rdmask = '0; r_wrmask = '0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      r_lat++;
      if (stb_any) r_stb++;
      r_rdmask |= dev_rd; r_wrmask |= dev_wr;
      if ((|dev_wr) && dev_done) r_word = dev_wdata;
      if (cpu_ack) break;
    end
    r_data = cpu_rdata;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); #1;
      chk("R7 ack held", 16'(cpu_ack), 16'd1);
    end
    @(negedge clk); cpu_req = 1'b0;
    @(posedge clk); #1;
    if (hold > 0) chk("R7 ack released", 16'(cpu_ack), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ack reset", 16'(cpu_ack), 16'd0);
    chk("R1 strobes reset", 16'({dev_rd, dev_wr}), 16'd0);
    chk("R1 rdata reset", 16'(cpu_rdata), 16'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: second halves straight after reset see cleared held bytes.
    cyc(1'b1, 1'b0, 8'h00, 2'b01, 0);
    chk("R1 read hi after reset", 16'(r_data), 16'h00);
    chk("R1 r3_ latency", 16'(r_lat), 16'd1);
    cyc(1'b1, 1'b1, 8'h3C, 2'b01, 0);
    chk("R1 write held lane cleared", r_word, 16'h3C00);

    // Main sweep: both devices, swap off and on, eight byte pairs.
    for (int d = 0; d < N; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0]  lo, hi;
          logic [15:0] w, exp_w;
          lo = 8'(k * 8'h29 + 8'h11);
          hi = 8'(~lo ^ 8'(k << 4));
          dev_swap = '0; dev_swap[d] = s[0];
          // write pair
          cyc(1'b0, 1'b1, lo, N'(1 << d), 0);
          chk("R4 write first latency", 16'(r_lat), 16'd1);
          chk("R4 write first no strobe", 16'(r_stb), 16'd0);
          cyc(1'b1, 1'b1, hi, N'(1 << d), 0);
          exp_w = s ? {lo, hi} : {hi, lo};
          chk(s ? "R6 write word swapped" : "R5 write word", r_word, exp_w);
          chk("R5 write strobe cycles", 16'(r_stb), 16'd3);
          chk("R5 write strobe target", 16'(r_wrmask), 16'(1 << d));
          chk("R5 write latency", 16'(r_lat), 16'd4);
          // read pair
          w = {8'(hi + 8'd1), 8'(lo ^ 8'h5A)};
          dev_rdata = '0;
          dev_rdata[d*16 +: 16] = w;
          cyc(1'b0, 1'b0, 8'h00, N'(1 << d), 0);
          chk(s ? "R6 read first swapped" : "R2 read first", 16'(r_data),
              16'(s ? w[15:8] : w[7:0]));
          chk("R2 read strobe target", 16'(r_rdmask), 16'(1 << d));
          chk("R2 read latency", 16'(r_lat), 16'd4);
          dev_rdata[d*16 +: 16] = ~w;
          cyc(1'b1, 1'b0, 8'h00, N'(1 << d), 0);
          chk(s ? "R6 read second swapped" : "R3 read second", 16'(r_data),
              16'(s ? w[7:0] : w[15:8]));
          chk("R3 read second no strobe", 16'(r_stb), 16'd0);
        end
      end
    end

    // R8: both selects set, lowest wins.
    dev_swap = '0;
    dev_rdata = {16'hBEEF, 16'h1234};
    cyc(1'b0, 1'b0, 8'h00, 2'b11, 0);
    chk("R8 lowest device strobed", 16'(r_rdmask), 16'b01);
    chk("R8 lowest device data", 16'(r_data), 16'h34);

    // R9: no select, held for a while, nothing happens.
    @(negedge clk);
    cpu_a0 = 1'b0; cpu_we = 1'b0; dev_sel = '0; cpu_req = 1'b1;
    r_stb = 0; r_lat = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (stb_any) r_stb++;
      if (cpu_ack) r_lat++;
    end
    chk("R9 no strobe", 16'(r_stb), 16'd0);
    chk("R9 no ack", 16'(r_lat), 16'd0);
    @(negedge clk); cpu_req = 1'b0;
    @(posedge clk);
    cyc(1'b1, 1'b0, 8'h00, 2'b01, 0);
    chk("R9 held byte untouched", 16'(r_data), 16'h12);

    // R7: hold request well past the acknowledge.
    cyc(1'b0, 1'b1, 8'h77, 2'b10, 3);
    cyc(1'b1, 1'b1, 8'h88, 2'b10, 3);
    chk("R7 write after held cycles", r_word, 16'h8877);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule